// File: doc/BRIEF.md
# Serial-Loaded Twelve-Channel Code Register Bank

This block is the digital front end of a twelve-channel, 8-bit converter output bank. A host writes it over three wires: a serial clock, a serial data line and a load strobe. Each write is a 12-bit frame made of a 4-bit channel number and an 8-bit code. The frame is shifted into a 12-bit shift register. A rising edge on the load strobe then copies the code into the holding register of the chosen channel. All twelve holding registers drive parallel code outputs for the analog stage. A serial output carries the shift register's oldest bit, so several banks can be chained on one link.

The three serial lines are asynchronous to the system clock. Each line passes through a synchroniser, and its edges are then found in the system clock domain. For this reason the host must hold each level of the serial clock and of the load strobe for at least SYNC_STAGES+1 system clock cycles. The host must also keep the data line stable around each serial clock rise. An active-low reset input takes the place of a power-on detector. It clears the bank asynchronously and is released in step with the system clock.

Top module: `dacbank_serial_top`

## Requirements
- R1: While reset is asserted, and right after it is released, every channel output reads 00h and ser_dout reads 0.
- R2: A frame is 12 bits sent most significant bit first, one bit per ser_clk rising edge. In the frame, bits 11..8 are the channel number and bits 7..0 are the code. A load with channel number k (1 to 12) puts the code on channel k. Channel k is driven on chan_code[8k-1:8k-8], so channel 1 is on bits [7:0].
- R3: A load changes at most one channel. Every channel other than the addressed one keeps its value.
- R4: A load whose channel number is 0, 13, 14 or 15 changes no channel.
- R5: Only a rising edge of ser_load starts an update. A frame shifted in while ser_load stays high is not applied until ser_load falls and rises again.
- R6: The new code appears on the output at the (SYNC_STAGES+1)th rising clk edge after ser_load goes high, which is the third edge with the default settings. Before that edge the old value stays on the output.
- R7: Each falling edge of ser_clk updates ser_dout to the bit that entered the shift register eleven rising edges before the most recent one. This bit is 0 if fewer than twelve rising edges have occurred since reset. The update appears within SYNC_STAGES+1 clk cycles.
- R8: ser_dout does not change on a rising edge of ser_clk, nor at any time between two falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit of the frame first |
| ser_load | input | 1 | Load strobe; its rising edge applies the held frame |
| ser_dout | output | 1 | Chaining output, updated on serial clock falls |
| chan_code | output | 96 | Twelve 8-bit channel codes, channel 1 in bits [7:0] |

## Verification
Every serial event takes SYNC_STAGES+1 clk edges to reach the outputs: two synchroniser stages, then the register that acts on the detected edge. With the default settings this is three edges. The bench drives inputs on falling clk edges and holds each serial level for four cycles, so it samples each result one cycle after it is due. For the load latency, the bench samples on the falling edge after the second rising edge and expects the old code, then samples again after the third rising edge and expects the new code. The chaining output is checked twice for every bit: once just before the serial clock rises, and once four cycles after the rise, where it must be unchanged.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned DEF_CODE_W  = 8;
  localparam int unsigned DEF_ADDR_W  = 4;
  localparam int unsigned DEF_NUM_CH  = 12;
  localparam int unsigned DEF_SYNC_ST = 2;

  // single-cycle events found on the synchronised serial lines
  typedef struct packed {
    logic clk_rise;
    logic clk_fall;
    logic load_rise;
  } ser_evt_t;
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/dacbank_shifter.sv
module dacbank_shifter
  import dacbank_pkg::*;
#(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               din_s,
  input  logic               load_s,
  output ser_evt_t           evt,
  output logic [FRAME_W-1:0] frame_q,
  output logic               dout_q
);
  logic               sclk_prev_q;
  logic               load_prev_q;
  logic               shift_en;
  logic               out_en;
  logic [FRAME_W-1:0] frame_d;
  logic               dout_d;

  // edge detection against the previous synchronised level
  always_comb begin
    evt.clk_rise  = sclk_s & ~sclk_prev_q;
    evt.clk_fall  = ~sclk_s & sclk_prev_q;
    evt.load_rise = load_s & ~load_prev_q;
  end

  // next-state: shift on serial rise, present oldest bit on serial fall
  always_comb begin
    shift_en = evt.clk_rise;
    out_en   = evt.clk_fall;
    frame_d  = {frame_q[FRAME_W-2:0], din_s};
    dout_d   = frame_q[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b0;
      frame_q     <= '0;
      dout_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      load_prev_q <= load_s;
      if (shift_en) begin
        frame_q <= frame_d;
      end
      if (out_en) begin
        dout_q <= dout_d;
      end
    end
  end
endmodule

// File: rtl/dacbank_latch_bank.sv
module dacbank_latch_bank #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_rise,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CODE_W-1:0]        code,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  logic [NUM_CH-1:0] sel;

  // channel numbers start at 1; zero and anything above NUM_CH match nothing
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      sel[i] = load_rise && (addr == ADDR_W'(i + 1));
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_chan
      logic [CODE_W-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q <= '0;
        end else if (sel[g]) begin
          hold_q <= code;
        end
      end

      assign codes[g*CODE_W +: CODE_W] = hold_q;
    end
  endgenerate
endmodule

// File: rtl/dacbank_serial_top.sv
module dacbank_serial_top
  import dacbank_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_ST
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_din,
  input  logic                     ser_load,
  output logic                     ser_dout,
  output logic [NUM_CH*CODE_W-1:0] chan_code
);
  localparam int unsigned FRAME_W = CODE_W + ADDR_W;

  logic               rst_q_n;
  logic [2:0]         lines_s;
  ser_evt_t           evt;
  logic [FRAME_W-1:0] frame_q;

  // reset: asserted at once, released after two clk edges
  dacbank_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (rst_q_n)
  );

  // all three serial lines go through the same depth so they stay aligned
  dacbank_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_line_sync (
    .clk  (clk),
    .rst_n(rst_q_n),
    .din  ({ser_clk, ser_din, ser_load}),
    .dout (lines_s)
  );

  dacbank_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .sclk_s (lines_s[2]),
    .din_s  (lines_s[1]),
    .load_s (lines_s[0]),
    .evt    (evt),
    .frame_q(frame_q),
    .dout_q (ser_dout)
  );

  dacbank_latch_bank #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_rise(evt.load_rise),
    .addr     (frame_q[FRAME_W-1 -: ADDR_W]),
    .code     (frame_q[CODE_W-1:0]),
    .codes    (chan_code)
  );
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk
  import dacbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input ser_evt_t                     evt,
  input logic [CODE_W+ADDR_W-1:0]     frame_q,
  input logic                         din_s,
  input logic                         ser_dout,
  input logic [NUM_CH*CODE_W-1:0]     chan_code
);
  localparam int unsigned FRAME_W = CODE_W + ADDR_W;

  logic [NUM_CH*CODE_W-1:0] code_prev_q;
  logic [NUM_CH-1:0]        lane_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_prev_q <= '0;
    end else begin
      code_prev_q <= chan_code;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      lane_chg[i] = chan_code[i*CODE_W +: CODE_W] != code_prev_q[i*CODE_W +: CODE_W];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chan_code == '0 && ser_dout == 1'b0));

  // R2
  frame_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clk_rise |=> frame_q == {$past(frame_q[FRAME_W-2:0]), $past(din_s)});

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.clk_rise |=> $stable(frame_q));

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lane
      // R2
      lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.load_rise && frame_q[FRAME_W-1 -: ADDR_W] == ADDR_W'(g + 1))
        |=> chan_code[g*CODE_W +: CODE_W] == $past(frame_q[CODE_W-1:0]));
    end
  endgenerate

  // R3
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_chg) <= 1);

  // R5
  change_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_chg != '0) |-> $past(evt.load_rise));

  // R4
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.load_rise && (frame_q[FRAME_W-1 -: ADDR_W] == '0 ||
                       frame_q[FRAME_W-1 -: ADDR_W] > ADDR_W'(NUM_CH)))
    |=> $stable(chan_code));

  // R7
  dout_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clk_fall |=> ser_dout == $past(frame_q[FRAME_W-1]));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.clk_fall |=> $stable(ser_dout));
endmodule

bind dacbank_serial_top dacbank_chk #(
  .NUM_CH(NUM_CH),
  .CODE_W(CODE_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .evt      (evt),
  .frame_q  (frame_q),
  .din_s    (lines_s[1]),
  .ser_dout (ser_dout),
  .chan_code(chan_code)
);

// File: tb/sim_dacbank_serial_top.sv
`timescale 1ns/1ps
module sim_dacbank_serial_top;
  localparam int NCH = 12;
  localparam int CW  = 8;
  localparam int BW  = NCH * CW;
  localparam int NVEC = 10;
  localparam logic [11:0] VEC_TBL [NVEC] = '{
    12'h1A5, 12'hC3C, 12'h0FF, 12'h57E, 12'hD11,
    12'h1FF, 12'hE22, 12'hB80, 12'hF33, 12'h601
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic ser_load = 1'b0;
  logic ser_dout;
  logic [BW-1:0] chan_code;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [NCH];
  logic hist [1024];
  int rise_cnt = 0;

  always #2 clk = ~clk;

  dacbank_serial_top u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .ser_dout(ser_dout), .chan_code(chan_code)
  );

  task automatic check(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [BW-1:0] model_bus();
    logic [BW-1:0] b;
    for (int i = 0; i < NCH; i++) b[i*CW +: CW] = model[i];
    return b;
  endfunction

  function automatic logic exp_dout();
    return (rise_cnt >= 12) ? hist[rise_cnt-12] : 1'b0;
  endfunction

  task automatic ser_bit(input logic b);
    logic e;
    @(negedge clk); ser_clk = 1'b0; ser_din = b;
    repeat (4) @(negedge clk);
    e = exp_dout();
    check("R7 dout after fall", BW'(ser_dout), BW'(e));
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    hist[rise_cnt] = b;
    rise_cnt++;
    check("R8 dout across rise", BW'(ser_dout), BW'(e));
  endtask

  task automatic send_frame(input logic [11:0] f);
    for (int i = 11; i >= 0; i--) ser_bit(f[i]);
    @(negedge clk); ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 dout after last fall", BW'(ser_dout), BW'(exp_dout()));
  endtask

  task automatic pulse_load();
    @(negedge clk); ser_load = 1'b1;
    repeat (6) @(negedge clk);
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic apply(input logic [11:0] f);
    int a;
    send_frame(f);
    pulse_load();
    a = int'(f[11:8]);
    if (a >= 1 && a <= NCH) model[a-1] = f[7:0];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run did not finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) model[i] = 8'h00;
    // R1: state during and after reset
    repeat (5) @(negedge clk);
    check("R1 codes in reset", chan_code, '0);
    check("R1 dout in reset", BW'(ser_dout), '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 codes after release", chan_code, '0);

    // table walk: R2/R3 on valid channels, R4 on 0,13,14,15
    for (int v = 0; v < NVEC; v++) begin
      int a;
      apply(VEC_TBL[v]);
      a = int'(VEC_TBL[v][11:8]);
      if (a >= 1 && a <= NCH) check("R2/R3 table load", chan_code, model_bus());
      else                    check("R4 ignored channel number", chan_code, model_bus());
    end

    // R2: every channel number 1..12 reaches its own lane
    for (int ch = 1; ch <= NCH; ch++) begin
      apply({4'(ch), 8'(ch * 17 + 3)});
      check("R2 channel sweep", chan_code, model_bus());
    end

    // R6: latency of a load
    send_frame(12'h35A);
    @(negedge clk); ser_load = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 old code before third edge", BW'(chan_code[2*CW +: CW]), BW'(model[2]));
    @(posedge clk);
    @(negedge clk);
    check("R6 new code at third edge", BW'(chan_code[2*CW +: CW]), BW'(8'h5A));
    model[2] = 8'h5A;
    ser_load = 1'b0;
    repeat (6) @(negedge clk);

    // R5: frame shifted with load held high is not applied
    send_frame(12'h411);
    @(negedge clk); ser_load = 1'b1;
    repeat (6) @(negedge clk);
    model[3] = 8'h11;
    send_frame(12'h499);
    check("R5 held load does not apply", chan_code, model_bus());
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 falling load does not apply", chan_code, model_bus());
    pulse_load();
    model[3] = 8'h99;
    check("R5 new rise applies", chan_code, model_bus());

    // R1: reset in mid run clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 codes after mid-run reset", chan_code, '0);
    check("R1 dout after mid-run reset", BW'(ser_dout), '0);
    rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) model[i] = 8'h00;
    rise_cnt = 0;
    repeat (5) @(negedge clk);

    // R7: chain output replays the previous frame MSB first
    apply(12'hC81);
    send_frame(12'hA5C);
    check("R3 no load means no change", chan_code, model_bus());
    finish_run();
  end
endmodule